// File: doc/BRIEF.md
# Weekday-Mask Minute Alarm Comparator

This block watches the time beats that a real-time-clock counter core emits and raises an alarm when the running hour and minute equal a programmed pair on a day that a seven-bit weekday mask selects. Each beat carries BCD seconds, minutes and hours and a weekday code from 0 to 6. Matching works at one-minute resolution. A beat counts only when its seconds field is zero, so one alarm fires at most once per minute. Because the day is picked by a mask and not by a date, an alarm can repeat on several days of the week, and it can never be set more than one week ahead.

Software programs the block through a plain write port with four registers: alarm minute, alarm hour, weekday mask, and a control register. The control register holds the interrupt enable and a write-one-to-clear strobe for the sticky alarm flag. The interrupt output is a level signal: it is high while the flag is set and the enable is on.

The time input uses a valid/ready handshake. The block never applies back-pressure, so ready stays high outside reset and every beat offered with valid high is accepted on that clock edge. Beats offered with valid low are ignored.

Top module: `wkalarm_cmp`

## Requirements
- R1: After reset the alarm flag and the interrupt are low, the interrupt enable is off, and the alarm minute, hour and weekday mask are all zero.
- R2: `t_ready` is high in every cycle after reset, so each beat with `t_valid` high is accepted at that clock edge.
- R3: An accepted beat matches when `t_sec` is 8'h00, `t_min` equals the alarm minute and `t_hour` equals the alarm hour, all compared as BCD bytes. A match sets the alarm flag, which shows on `alarm_flag` in the cycle after the edge that accepted the beat.
- R4: Weekday mask bit n (n = 0..6) selects weekday code n. When several bits are set, the alarm fires on each of those days. Weekday code 7 never matches.
- R5: A beat offered with `t_valid` low has no effect on the flag, whatever its fields hold.
- R6: Within a run of consecutive accepted beats that all match, only the first one sets the flag. A later run can set it again once a non-matching beat has been accepted in between.
- R7: The flag is sticky. A write of 1 to bit 0 of the control register (address 3) clears it, and a write with bit 0 at 0 leaves it alone. If a detection and a clear fall on the same edge, the flag ends up set.
- R8: `irq` equals the flag ANDed with the enable in bit 4 of the control register. The flag still sets while the enable is off.
- R9: A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr`: 0 is the alarm minute, 1 the alarm hour, 2 the weekday mask (bits 6:0) and 3 the control register. The new value applies only to beats accepted after the writing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_valid | input | 1 | Time beat valid |
| t_ready | output | 1 | Time beat ready (high outside reset) |
| t_sec | input | 8 | BCD seconds of the beat |
| t_min | input | 8 | BCD minutes of the beat |
| t_hour | input | 8 | BCD hours of the beat |
| t_wday | input | 3 | Weekday code of the beat, 0..6 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the following corner cases, and each one catches a specific fault.
- **Repeated matching beat.** The same matching beat is offered twice, with the flag cleared between the two. A design without the first-of-run rule raises the flag a second time for the same minute.
- **Clear on the detection edge.** A clear is written on the same edge that detects a match. A design that gives the clear priority loses the alarm.
- **Weekday code 7 with a full mask.** A design that indexes the mask without a range check fires on this code.
- **Alarm registers rewritten on a beat edge.** The alarm registers are written on the same edge as a beat. A design that compares against the new value matches one beat early.
- **Enable off at detection.** The enable is off when the match happens. A design that gates the flag instead of the output never raises the interrupt once the enable is turned on.

// File: rtl/wkalarm_pkg.sv
package wkalarm_pkg;
  localparam int BCD_W   = 8;
  localparam int DAYS    = 7;
  localparam int DAY_W   = $clog2(DAYS + 1);
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int ENA_BIT = 4;
  localparam int CLR_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MIN  = 2'd0,
    SEL_HOUR = 2'd1,
    SEL_MASK = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [BCD_W-1:0] minute;
    logic [BCD_W-1:0] hour;
    logic [DAYS-1:0]  mask;
    logic             enable;
  } alarm_cfg_t;
endpackage

// File: rtl/wkalarm_regs.sv
module wkalarm_regs
  import wkalarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output alarm_cfg_t        cfg,
  output logic              clr_req
);
  alarm_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      unique case (reg_sel_e'(addr))
        SEL_MIN:  cfg_q.minute <= wdata[BCD_W-1:0];
        SEL_HOUR: cfg_q.hour   <= wdata[BCD_W-1:0];
        SEL_MASK: cfg_q.mask   <= wdata[DAYS-1:0];
        SEL_CTRL: cfg_q.enable <= wdata[ENA_BIT];
        default:  cfg_q        <= cfg_q;
      endcase
    end
  end

  assign cfg     = cfg_q;
  assign clr_req = we && (reg_sel_e'(addr) == SEL_CTRL) && wdata[CLR_BIT];
endmodule

// File: rtl/wkalarm_match.sv
module wkalarm_match
  import wkalarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [BCD_W-1:0] sec,
  input  logic [BCD_W-1:0] minute,
  input  logic [BCD_W-1:0] hour,
  input  logic [DAY_W-1:0] wday,
  input  alarm_cfg_t       cfg,
  output logic             hit
);
  logic [DAYS-1:0] day_sel;
  logic            day_ok;
  logic            time_ok;
  logic            raw;
  logic            prev_q;

  for (genvar d = 0; d < DAYS; d++) begin : g_day
    assign day_sel[d] = cfg.mask[d] && (wday == DAY_W'(d));
  end

  assign day_ok  = |day_sel;
  assign time_ok = (sec == '0) && (minute == cfg.minute) && (hour == cfg.hour);
  assign raw     = day_ok && time_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_q <= 1'b0;
    else if (beat) prev_q <= raw;
  end

  assign hit = beat && raw && !prev_q;
endmodule

// File: rtl/wkalarm_flag.sv
module wkalarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic enable,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q && enable;
endmodule

// File: rtl/wkalarm_cmp.sv
module wkalarm_cmp
  import wkalarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t_valid,
  output logic              t_ready,
  input  logic [BCD_W-1:0]  t_sec,
  input  logic [BCD_W-1:0]  t_min,
  input  logic [BCD_W-1:0]  t_hour,
  input  logic [DAY_W-1:0]  t_wday,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              alarm_flag,
  output logic              irq
);
  alarm_cfg_t cfg;
  logic       clr_req;
  logic       hit;
  logic       beat;
  logic       alm_en;

  assign t_ready = rst_n;
  assign beat    = t_valid && t_ready;
  assign alm_en  = cfg.enable;

  wkalarm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .cfg     (cfg),
    .clr_req (clr_req)
  );

  wkalarm_match u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .beat   (beat),
    .sec    (t_sec),
    .minute (t_min),
    .hour   (t_hour),
    .wday   (t_wday),
    .cfg    (cfg),
    .hit    (hit)
  );

  wkalarm_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .clr    (clr_req),
    .enable (cfg.enable),
    .flag   (alarm_flag),
    .irq    (irq)
  );
endmodule

// File: rtl/wkalarm_chk.sv
module wkalarm_chk
  import wkalarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              t_valid,
  input logic              t_ready,
  input logic [BCD_W-1:0]  t_sec,
  input logic [DAY_W-1:0]  t_wday,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              alarm_flag,
  input logic              irq,
  input logic              alm_en
);
  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_addr == ADDR_W'(3)) && cfg_wdata[CLR_BIT];

  AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    t_ready) else $error("ready low"); // R2

  AST_RISE_NEEDS_SEC0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> ($past(t_sec) == '0)) else $error("rise without sec0"); // R3

  AST_RISE_VALID_DAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> ($past(t_wday) < DAY_W'(DAYS))) else $error("bad day"); // R4

  AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !t_valid |=> !$rose(alarm_flag)) else $error("idle beat set flag"); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !clr_wr) |=> alarm_flag) else $error("flag dropped"); // R7

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (alm_en && alarm_flag)) else $error("irq without enable"); // R8
endmodule

bind wkalarm_cmp wkalarm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .t_valid    (t_valid),
  .t_ready    (t_ready),
  .t_sec      (t_sec),
  .t_wday     (t_wday),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .alarm_flag (alarm_flag),
  .irq        (irq),
  .alm_en     (alm_en)
);

// File: tb/sim_wkalarm_cmp.sv
module sim_wkalarm_cmp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       t_valid = 1'b0;
  logic       t_ready;
  logic [7:0] t_sec = 8'h00, t_min = 8'h00, t_hour = 8'h00;
  logic [2:0] t_wday = 3'd0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       alarm_flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_min = 0, m_hour = 0, m_mask = 0;
  bit m_en = 0, m_flag = 0, m_prev = 0;

  always #4 clk = ~clk;

  wkalarm_cmp u0 (
    .clk(clk), .rst_n(rst_n), .t_valid(t_valid), .t_ready(t_ready),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_wday(t_wday),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .alarm_flag(alarm_flag), .irq(irq)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit raw, det, clr;
    raw = (t_sec == 8'h00) && (int'(t_min) == m_min) && (int'(t_hour) == m_hour)
          && (t_wday < 3'd7) && m_mask[t_wday];
    det = t_valid && raw && !m_prev;
    clr = cfg_we && (cfg_addr == 2'd3) && cfg_wdata[0];
    if (det) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    if (t_valid) m_prev = raw;
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: m_min = int'(cfg_wdata);
        2'd1: m_hour = int'(cfg_wdata);
        2'd2: m_mask = int'(cfg_wdata[6:0]);
        default: m_en = cfg_wdata[4];
      endcase
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R2", "t_ready", int'(t_ready), 1);
    check(cur_req, "model flag", int'(alarm_flag), int'(m_flag));
    check(cur_req, "model irq", int'(irq), int'(m_flag && m_en));
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic beat(input logic [7:0] h, input logic [7:0] m,
                      input logic [7:0] s, input logic [2:0] w);
    t_valid = 1'b1; t_hour = h; t_min = m; t_sec = s; t_wday = w;
    cyc();
    t_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "flag in reset", int'(alarm_flag), 0);
    check("R1", "irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    cur_req = "R1";
    cyc();
    // R1: zero alarm regs with empty mask must not match 00:00:00
    beat(8'h00, 8'h00, 8'h00, 3'd0);
    check("R1", "empty mask no match", int'(alarm_flag), 0);

    cur_req = "R9";
    wr(2'd0, 8'h30); wr(2'd1, 8'h12); wr(2'd2, 8'h04); wr(2'd3, 8'h10);
    beat(8'h11, 8'h59, 8'h59, 3'd2);

    cur_req = "R3";
    beat(8'h12, 8'h30, 8'h00, 3'd2);
    check("R3", "flag after match", int'(alarm_flag), 1);
    check("R8", "irq with enable", int'(irq), 1);

    cur_req = "R7";
    wr(2'd3, 8'h10);
    check("R7", "write bit0=0 keeps flag", int'(alarm_flag), 1);
    wr(2'd3, 8'h11);
    check("R7", "w1c clears flag", int'(alarm_flag), 0);

    cur_req = "R3";
    beat(8'h12, 8'h30, 8'h01, 3'd2);
    beat(8'h12, 8'h31, 8'h00, 3'd2);
    beat(8'h13, 8'h30, 8'h00, 3'd2);
    check("R3", "near misses", int'(alarm_flag), 0);

    cur_req = "R4";
    beat(8'h12, 8'h30, 8'h00, 3'd3);
    check("R4", "unselected day", int'(alarm_flag), 0);
    wr(2'd2, 8'h28);
    beat(8'h12, 8'h30, 8'h00, 3'd3);
    check("R4", "day 3 selected", int'(alarm_flag), 1);
    wr(2'd3, 8'h11);
    beat(8'h12, 8'h29, 8'h00, 3'd4);
    beat(8'h12, 8'h30, 8'h00, 3'd5);
    check("R4", "day 5 selected", int'(alarm_flag), 1);
    wr(2'd3, 8'h11);
    wr(2'd2, 8'hFF);
    beat(8'h00, 8'h00, 8'h00, 3'd0);
    beat(8'h12, 8'h30, 8'h00, 3'd7);
    check("R4", "code 7 never matches", int'(alarm_flag), 0);

    cur_req = "R5";
    t_valid = 1'b0; t_hour = 8'h12; t_min = 8'h30; t_sec = 8'h00; t_wday = 3'd1;
    cyc(); cyc();
    check("R5", "invalid beat ignored", int'(alarm_flag), 0);

    cur_req = "R6";
    beat(8'h12, 8'h30, 8'h00, 3'd1);
    check("R6", "first of run sets", int'(alarm_flag), 1);
    wr(2'd3, 8'h11);
    beat(8'h12, 8'h30, 8'h00, 3'd1);
    check("R6", "repeat in run ignored", int'(alarm_flag), 0);
    beat(8'h12, 8'h30, 8'h02, 3'd1);
    beat(8'h12, 8'h30, 8'h00, 3'd1);
    check("R6", "new run sets", int'(alarm_flag), 1);

    cur_req = "R7";
    beat(8'h12, 8'h31, 8'h00, 3'd1);
    wr(2'd3, 8'h11);
    t_valid = 1'b1; t_hour = 8'h12; t_min = 8'h30; t_sec = 8'h00; t_wday = 3'd6;
    cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 8'h11;
    cyc();
    t_valid = 1'b0; cfg_we = 1'b0;
    check("R7", "set beats clear", int'(alarm_flag), 1);

    cur_req = "R8";
    wr(2'd3, 8'h01);
    beat(8'h12, 8'h31, 8'h00, 3'd0);
    beat(8'h12, 8'h30, 8'h00, 3'd0);
    check("R8", "flag sets while disabled", int'(alarm_flag), 1);
    check("R8", "irq gated off", int'(irq), 0);
    wr(2'd3, 8'h10);
    check("R8", "irq after enable", int'(irq), 1);

    cur_req = "R9";
    wr(2'd3, 8'h11);
    beat(8'h12, 8'h31, 8'h00, 3'd0);
    t_valid = 1'b1; t_hour = 8'h12; t_min = 8'h45; t_sec = 8'h00; t_wday = 3'd0;
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h45;
    cyc();
    t_valid = 1'b0; cfg_we = 1'b0;
    check("R9", "write applies after edge", int'(alarm_flag), 0);
    beat(8'h12, 8'h44, 8'h00, 3'd0);
    beat(8'h12, 8'h45, 8'h00, 3'd0);
    check("R9", "new minute matches", int'(alarm_flag), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule